// File: doc/BRIEF.md
# Three-Level PWM Gate Command Decoder

This block sits between a window comparator and the two gate drivers of a synchronous buck power stage. The comparator reports the PWM line as two digital flags: one says the line is above the upper threshold, the other says it is below the lower threshold. When neither flag is set, the line sits in the middle window. The decoder resynchronises the flags and filters the middle level through a hold-off timer, so that it reaches a tri-state command only when the line stays in the window long enough. It then drives the high-side and low-side gate enables through a break-before-make sequencer that inserts a dead time, with a separate count for each direction.

Three side inputs shape the result. A ready input keeps both gates off until the power stage is allowed to switch. A low-side enable can block the low-side gate, which leaves the stage in a diode-emulation style in which a low command turns both gates off. A fault input blocks the high-side gate while the low-side gate still follows low and tri-state commands. Every delay is counted in clock cycles and is set by a parameter.

The hold-off filter is a five-state machine. `HO_TRI` is the reset state and means both gates are commanded off. `HO_LOW` and `HO_HIGH` mean the line is settled low or high. `HO_WAIT_LO` and `HO_WAIT_HI` mean the line is in the window and the timer is running; the previous command still applies during this time. The transitions are:
- settled-to-wait, taken when the window is first seen;
- wait-to-tri, taken when the count reaches the hold-off for the level the line came from;
- wait-to-settled and tri-to-settled, taken at once when a high or low level is seen.

The gate sequencer is a three-state machine. `GS_IDLE` has both gates off, `GS_HS` has the high side on and `GS_LS` has the low side on. The transitions are:
- idle-to-on, taken when a gate is requested and its dead time since the opposite gate went off has elapsed;
- on-to-idle, taken when the request for that gate goes away.

Top module: `tristate_gate_decoder`

## Requirements
- R1: The flags are decoded with a 2-bit code (above, below). The code 10 means high and 01 means low. Code 00, which is what an undriven line produces, and the illegal code 11 both mean the middle window. A middle window held long enough ends with both gates off.
- R2: After a settled low, a middle-window input drops the low-side gate at the (HOLD_AFTER_LO+4)-th rising clock edge after the input changes.
- R3: After a settled high, a middle-window input drops the high-side gate at the (HOLD_AFTER_HI+4)-th rising edge after the input changes. The default hold-off after high is longer than the one after low.
- R4: Leaving the window takes effect with no hold-off. A window pulse of HOLD_AFTER_LO cycles after a low leaves the low-side gate on throughout. From the tri-state, a new command switches its gate at the 4th rising edge when no dead time is owed.
- R5: With the low-side enable high and ready high, a high command gives high-side gate 1 and low-side gate 0. A low command gives high-side gate 0 and low-side gate 1.
- R6: With the low-side enable low, the low-side gate is 0 and a high command still turns on the high-side gate, so a low command leaves both gates off. Lowering the enable drops an active low-side gate at the next edge.
- R7: The two gates are never on together. The low-side gate rises DT_H2L edges after the high-side gate falls, and the high-side gate rises DT_L2H edges after the low-side gate falls.
- R8: While ready is low, both gates are low whatever the other inputs are. Dropping ready turns an active gate off at the next edge.
- R9: The fault input forces the high-side gate low at the next edge even under a high command. The low-side gate still follows low and tri-state commands while the fault input is set.
- R10: During and right after reset both gates are low and the filter is in the tri-state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_above_i | input | 1 | Comparator flag: line above upper threshold |
| win_below_i | input | 1 | Comparator flag: line below lower threshold |
| ls_enable_i | input | 1 | Low-side gate enable |
| stage_ready_i | input | 1 | Power stage ready; gates held off while low |
| hs_block_i | input | 1 | Fault gate-off for the high side |
| gate_hs_o | output | 1 | High-side gate enable |
| gate_ls_o | output | 1 | Low-side gate enable |

## Verification
The hardest situation to reach from the ports is the exact boundary of the hold-off timer. A window pulse one cycle shorter than the threshold must leave the gate untouched, while a long enough one must drop it at a precise edge. Between the two lie the two synchroniser flops and the filter's entry cycle. The stimulus drives the flags at falling edges. It holds the window for exactly HOLD_AFTER_LO cycles and then returns to low, watching the low-side gate on every cycle. It also holds the window without limit and counts the edges until each gate falls, after settling the line low and then high so that both hold-off values are used. Dead time is measured the same way: the bench counts edges from the fall of one gate to the rise of the other in both directions.

// File: rtl/tgd_pkg.sv
package tgd_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_MID  = 2'd2
    } line_level_e;

    typedef enum logic [1:0] {
        CMD_LO  = 2'd0,
        CMD_HI  = 2'd1,
        CMD_TRI = 2'd2
    } gate_cmd_e;

    // Flags are {above, below}; anything but a single flag is the window.
    function automatic line_level_e classify_flags(input logic above, input logic below);
        line_level_e lvl;
        if (above && !below) begin
            lvl = LVL_HIGH;
        end else if (below && !above) begin
            lvl = LVL_LOW;
        end else begin
            lvl = LVL_MID;
        end
        return lvl;
    endfunction

endpackage

// File: rtl/tgd_flag_sync.sv
module tgd_flag_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/tgd_holdoff_fsm.sv
module tgd_holdoff_fsm
    import tgd_pkg::*;
#(
    parameter int HOLD_AFTER_LO = 7,
    parameter int HOLD_AFTER_HI = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  line_level_e level_i,
    output gate_cmd_e   cmd_o
);

    localparam int HOLD_MAX = (HOLD_AFTER_LO > HOLD_AFTER_HI) ? HOLD_AFTER_LO : HOLD_AFTER_HI;
    localparam int CW       = $clog2(HOLD_MAX + 2);
    localparam logic [CW-1:0] HOLD_LO_C = CW'(HOLD_AFTER_LO);
    localparam logic [CW-1:0] HOLD_HI_C = CW'(HOLD_AFTER_HI);

    typedef enum logic [2:0] {
        HO_TRI     = 3'd0,
        HO_LOW     = 3'd1,
        HO_HIGH    = 3'd2,
        HO_WAIT_LO = 3'd3,
        HO_WAIT_HI = 3'd4
    } holdoff_state_e;

    holdoff_state_e state_q, state_d;
    logic [CW-1:0]  hold_cnt_q;
    logic           waiting;

    assign waiting = (state_q == HO_WAIT_LO) || (state_q == HO_WAIT_HI);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HO_LOW: begin
                if (level_i == LVL_HIGH)     state_d = HO_HIGH;
                else if (level_i == LVL_MID) state_d = HO_WAIT_LO;
            end
            HO_HIGH: begin
                if (level_i == LVL_LOW)      state_d = HO_LOW;
                else if (level_i == LVL_MID) state_d = HO_WAIT_HI;
            end
            HO_WAIT_LO: begin
                if (level_i == LVL_HIGH)       state_d = HO_HIGH;
                else if (level_i == LVL_LOW)   state_d = HO_LOW;
                else if (hold_cnt_q >= HOLD_LO_C) state_d = HO_TRI;
            end
            HO_WAIT_HI: begin
                if (level_i == LVL_HIGH)       state_d = HO_HIGH;
                else if (level_i == LVL_LOW)   state_d = HO_LOW;
                else if (hold_cnt_q >= HOLD_HI_C) state_d = HO_TRI;
            end
            HO_TRI: begin
                if (level_i == LVL_HIGH)     state_d = HO_HIGH;
                else if (level_i == LVL_LOW) state_d = HO_LOW;
            end
            default: state_d = HO_TRI;
        endcase
    end

    // State register and hold-off counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= HO_TRI;
            hold_cnt_q <= CW'(1);
        end else begin
            state_q    <= state_d;
            hold_cnt_q <= waiting ? hold_cnt_q + 1'b1 : CW'(1);
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            HO_LOW, HO_WAIT_LO:  cmd_o = CMD_LO;
            HO_HIGH, HO_WAIT_HI: cmd_o = CMD_HI;
            default:             cmd_o = CMD_TRI;
        endcase
    end

    assert_high_resumes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i == LVL_HIGH) |=> (cmd_o == CMD_HI))
        else $error("R4: high level did not reach the command at once");

    assert_low_resumes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i == LVL_LOW) |=> (cmd_o == CMD_LO))
        else $error("R4: low level did not reach the command at once");

    assert_tri_needs_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_o == CMD_TRI) |-> $past(level_i == LVL_MID))
        else $error("R1: tri-state entered without a window level");

    assert_tri_after_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_o == CMD_TRI) |-> $past(waiting))
        else $error("R2: tri-state entered without a hold-off wait");

endmodule

// File: rtl/tgd_gate_seq.sv
module tgd_gate_seq
    import tgd_pkg::*;
#(
    parameter int DT_H2L = 3,
    parameter int DT_L2H = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  gate_cmd_e cmd_i,
    input  logic      ls_enable_i,
    input  logic      ready_i,
    input  logic      hs_block_i,
    output logic      gate_hs_o,
    output logic      gate_ls_o
);

    localparam int DT_MAX = (DT_H2L > DT_L2H) ? DT_H2L : DT_L2H;
    localparam int SW     = $clog2(DT_MAX + 1);
    localparam logic [SW-1:0] DT_MAX_C = SW'(DT_MAX);
    localparam logic [SW-1:0] DT_H2L_C = SW'(DT_H2L);
    localparam logic [SW-1:0] DT_L2H_C = SW'(DT_L2H);

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_HS   = 2'd1,
        GS_LS   = 2'd2
    } gate_state_e;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_HS   = 2'd1,
        SIDE_LS   = 2'd2
    } last_side_e;

    gate_state_e   state_q, state_d;
    last_side_e    last_off_q;
    logic [SW-1:0] since_off_q;
    logic          want_hs, want_ls, hs_clear, ls_clear;

    assign want_hs  = ready_i && !hs_block_i && (cmd_i == CMD_HI);
    assign want_ls  = ready_i && ls_enable_i && (cmd_i == CMD_LO);
    assign hs_clear = (last_off_q != SIDE_LS) || (since_off_q >= DT_L2H_C);
    assign ls_clear = (last_off_q != SIDE_HS) || (since_off_q >= DT_H2L_C);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE: begin
                if (want_hs && hs_clear)      state_d = GS_HS;
                else if (want_ls && ls_clear) state_d = GS_LS;
            end
            GS_HS:   if (!want_hs) state_d = GS_IDLE;
            GS_LS:   if (!want_ls) state_d = GS_IDLE;
            default: state_d = GS_IDLE;
        endcase
    end

    // State register with dead-time bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= GS_IDLE;
            last_off_q  <= SIDE_NONE;
            since_off_q <= DT_MAX_C;
        end else begin
            state_q <= state_d;
            if (state_q == GS_HS && state_d == GS_IDLE) last_off_q <= SIDE_HS;
            if (state_q == GS_LS && state_d == GS_IDLE) last_off_q <= SIDE_LS;
            if (state_q != GS_IDLE)         since_off_q <= SW'(1);
            else if (since_off_q < DT_MAX_C) since_off_q <= since_off_q + 1'b1;
        end
    end

    // Output decode
    always_comb begin
        gate_hs_o = 1'b0;
        gate_ls_o = 1'b0;
        unique case (state_q)
            GS_HS:   gate_hs_o = 1'b1;
            GS_LS:   gate_ls_o = 1'b1;
            default: ;
        endcase
    end

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hs_o && gate_ls_o))
        else $error("R7: both gates on");

    assert_ls_rise_after_hs_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_ls_o) |-> (!gate_hs_o && !$past(gate_hs_o)))
        else $error("R7: low side rose while high side was on");

    assert_hs_rise_after_ls_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hs_o) |-> (!gate_ls_o && !$past(gate_ls_o)))
        else $error("R7: high side rose while low side was on");

    assert_not_ready_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> (!gate_hs_o && !gate_ls_o))
        else $error("R8: gate on while not ready");

    assert_fault_blocks_hs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hs_block_i |=> !gate_hs_o)
        else $error("R9: high side on during fault gate-off");

    assert_ls_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_enable_i |=> !gate_ls_o)
        else $error("R6: low side on while disabled");

endmodule

// File: rtl/tristate_gate_decoder.sv
module tristate_gate_decoder #(
    parameter int SYNC_STAGES   = 2,
    parameter int HOLD_AFTER_LO = 7,
    parameter int HOLD_AFTER_HI = 8,
    parameter int DT_H2L        = 3,
    parameter int DT_L2H        = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win_above_i,
    input  logic win_below_i,
    input  logic ls_enable_i,
    input  logic stage_ready_i,
    input  logic hs_block_i,
    output logic gate_hs_o,
    output logic gate_ls_o
);
    import tgd_pkg::*;

    logic [1:0]  flags_sync;
    line_level_e level;
    gate_cmd_e   cmd;

    tgd_flag_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({win_above_i, win_below_i}),
        .sync_o  (flags_sync)
    );

    assign level = classify_flags(flags_sync[1], flags_sync[0]);

    tgd_holdoff_fsm #(
        .HOLD_AFTER_LO (HOLD_AFTER_LO),
        .HOLD_AFTER_HI (HOLD_AFTER_HI)
    ) u_holdoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level),
        .cmd_o   (cmd)
    );

    tgd_gate_seq #(
        .DT_H2L (DT_H2L),
        .DT_L2H (DT_L2H)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .ls_enable_i (ls_enable_i),
        .ready_i     (stage_ready_i),
        .hs_block_i  (hs_block_i),
        .gate_hs_o   (gate_hs_o),
        .gate_ls_o   (gate_ls_o)
    );

    assert_reset_tri_R10: assert property (@(posedge clk)
        !rst_n |-> (cmd == CMD_TRI && !gate_hs_o && !gate_ls_o))
        else $error("R10: not in the safe state during reset");

endmodule

// File: tb/tristate_gate_decoder_tb.sv
module tristate_gate_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD_LO    = 7;
    localparam int HOLD_HI    = 8;
    localparam int DTHL       = 3;
    localparam int DTLH       = 2;
    localparam int SETTLE     = 25;

    // {above, below, ls_en, ready, block, exp_gh, exp_gl}
    localparam int NVEC = 12;
    localparam logic [6:0] VEC [NVEC] = '{
        7'b1011010, 7'b0111001, 7'b0011000, 7'b1011010,
        7'b1111000, 7'b0101000, 7'b1001010, 7'b1011100,
        7'b0111101, 7'b1010000, 7'b0111001, 7'b0011000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above = 1'b0, below = 1'b0, lsen = 1'b1, rdy = 1'b0, blk = 1'b0;
    logic gh, gl;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tristate_gate_decoder #(
        .HOLD_AFTER_LO (HOLD_LO),
        .HOLD_AFTER_HI (HOLD_HI),
        .DT_H2L        (DTHL),
        .DT_L2H        (DTLH)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .win_above_i   (above),
        .win_below_i   (below),
        .ls_enable_i   (lsen),
        .stage_ready_i (rdy),
        .hs_block_i    (blk),
        .gate_hs_o     (gh),
        .gate_ls_o     (gl)
    );

    function automatic string vec_req(input int idx);
        case (idx)
            2, 4:    return "R1";
            5, 6:    return "R6";
            7, 8:    return "R9";
            9:       return "R8";
            11:      return "R2";
            default: return "R5";
        endcase
    endfunction

    task automatic check_val(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic a, input logic b, input logic l, input logic r, input logic k);
        @(negedge clk);
        above = a; below = b; lsen = l; rdy = r; blk = k;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Counts rising edges until the chosen gate shows val; -1 if never.
    task automatic count_until(input bit pick_hs, input logic val, input int limit, output int n);
        int i = 0;
        n = -1;
        while (n < 0 && i < limit) begin
            i++;
            @(posedge clk);
            @(negedge clk);
            if ((pick_hs ? gh : gl) == val) n = i;
        end
    endtask

    initial begin
        int n;
        int bad;
        // R10: reset state
        repeat (3) @(negedge clk);
        check_val("R10", "gh in reset", int'(gh), 0);
        check_val("R10", "gl in reset", int'(gl), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: not ready keeps gates off under a high command
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        settle(SETTLE);
        check_val("R8", "gh before ready", int'(gh), 0);
        check_val("R10", "gl after reset", int'(gl), 0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            drive(VEC[v][6], VEC[v][5], VEC[v][4], VEC[v][3], VEC[v][2]);
            settle(SETTLE);
            check_val(vec_req(v), $sformatf("vec %0d gh", v), int'(gh), int'(VEC[v][1]));
            check_val(vec_req(v), $sformatf("vec %0d gl", v), int'(gl), int'(VEC[v][0]));
        end

        // R2: hold-off after low
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0); settle(SETTLE);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        count_until(1'b0, 1'b0, 60, n);
        check_val("R2", "edges to gl off", n, HOLD_LO + 4);

        // R3: hold-off after high
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0); settle(SETTLE);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        count_until(1'b1, 1'b0, 60, n);
        check_val("R3", "edges to gh off", n, HOLD_HI + 4);

        // R4: leaving tri-state resumes at once
        settle(5);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        count_until(1'b1, 1'b1, 60, n);
        check_val("R4", "edges tri to gh on", n, 4);

        // R7: high to low with dead time
        settle(SETTLE);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        count_until(1'b1, 1'b0, 60, n);
        check_val("R7", "edges to gh off", n, 4);
        count_until(1'b0, 1'b1, 60, n);
        check_val("R7", "dead time gh off to gl on", n, DTHL);

        // R7: low to high with dead time
        settle(SETTLE);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        count_until(1'b0, 1'b0, 60, n);
        check_val("R7", "edges to gl off", n, 4);
        count_until(1'b1, 1'b1, 60, n);
        check_val("R7", "dead time gl off to gh on", n, DTLH);

        // R4: window pulse shorter than hold-off
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0); settle(SETTLE);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        bad = 0;
        for (int i = 0; i < HOLD_LO; i++) begin
            @(posedge clk); @(negedge clk);
            if (gl !== 1'b1) bad++;
        end
        above = 1'b0; below = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); @(negedge clk);
            if (gl !== 1'b1) bad++;
        end
        check_val("R4", "cycles gl dropped on short window", bad, 0);

        // R9: fault gate-off drops high side next edge
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0); settle(SETTLE);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        count_until(1'b1, 1'b0, 10, n);
        check_val("R9", "edges fault to gh off", n, 1);

        // R8: dropping ready turns low side off next edge
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0); settle(SETTLE);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        count_until(1'b0, 1'b0, 10, n);
        check_val("R8", "edges ready low to gl off", n, 1);

        // R6: lowering enable drops low side next edge
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0); settle(SETTLE);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        count_until(1'b0, 1'b0, 10, n);
        check_val("R6", "edges enable low to gl off", n, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule